// File: doc/BRIEF.md
# Receive Credit and Link Activation Controller

This controller lives on the application side of a receive channel that uses credit flow control. Each credit stands for one packet buffer slot. The core asks for the channel by raising an activation request. The controller answers with an acknowledge once its buffer reports ready. It then issues credits to the core as single-cycle grant pulses: first the whole pool, at one pulse per clock, and after that one pulse each time the buffer frees a slot. Buffer occupancy reaches the controller as two pulse inputs, one when a packet lands (a credit is used) and one when a slot is released.

To shut the channel, local control pulses a deactivation request. The controller then raises a hint toward the core. The core hands unused credits back on a return pulse and drops its request. The controller re-enters its stopped state only when every credit it issued has been either used or returned. A sticky error flag reports accounting faults. All pins are plain level or single-cycle pulse signals. There is no data path, so no valid/ready stream and no back-pressure applies at this block's edge.

Top module: `credit_link_ctrl`

## Requirements
- R1: After reset, the state is stopped (link_state_o = 0), and act_ack_o, deact_hint_o, credit_grant_o, credit_err_o and credits_out_o are all 0.
- R2: link_state_o encodes stopped=0, activating=1, active=2, deactivating=3. A request in stopped moves to activating. Activating moves to active and raises act_ack_o on the edge where the request and buf_ready_i are both high. Dropping the request while activating returns to stopped without an acknowledge.
- R3: Starting the cycle after act_ack_o rises, credit_grant_o pulses on consecutive cycles, one pulse per clock, until the whole pool of NUM_CREDITS credits has been granted.
- R4: The number of credits granted and not yet used or returned, plus the slots holding packets, never exceeds NUM_CREDITS. Each slot_free_i pulse allows exactly one further grant.
- R5: credit_grant_o pulses only when the previous cycle was in the active state with the request high and no deactivation request.
- R6: A deact_req_i pulse in the active state moves to deactivating and raises deact_hint_o on that edge. The hint stays high until the core's request is seen low, and falls on the following edge.
- R7: deact_req_i while already deactivating has no effect: deact_hint_o does not rise again.
- R8: Each credit_return_i pulse lowers the outstanding count by one and puts the credit back in the pool. After a full drain, reactivation grants the whole pool again.
- R9: Deactivating moves to stopped only when the request is low and the outstanding count is zero. act_ack_o falls on the edge after the request is seen low.
- R10: credit_err_o rises if pkt_consume_i and credit_return_i together exceed the outstanding count. It stays high until reset.
- R11: credit_err_o rises on a credit_return_i pulse while no credits are outstanding.
- R12: credits_out_o equals credits granted minus packets consumed minus credits returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_req_i | input | 1 | Core's activation request, held high while the channel is needed |
| act_ack_o | output | 1 | Acknowledge to the core; the channel is usable |
| buf_ready_i | input | 1 | Local buffer ready to accept packets |
| deact_req_i | input | 1 | Local control asks for deactivation (pulse) |
| deact_hint_o | output | 1 | Hint to the core to return credits and stop |
| credit_grant_o | output | 1 | One-credit grant pulse to the core |
| credit_return_i | input | 1 | One-credit return pulse from the core |
| pkt_consume_i | input | 1 | A packet used one credit and now occupies a slot |
| slot_free_i | input | 1 | One buffer slot was released |
| credits_out_o | output | $clog2(NUM_CREDITS+1) | Credits currently held by the core |
| link_state_o | output | 2 | Controller state, encoding as in R2 |
| credit_err_o | output | 1 | Sticky credit accounting error |

## Verification
Some properties are checked on every cycle: grants appear only after an active cycle, the hint clears once the request drops, the stopped state is reached only after the count has drained, the pool bound holds, and the error flag is sticky. Other behaviour can only be shown by the bench's scenarios. These are the exact length of the initial grant burst, the single extra grant that follows a slot release, the hint ignoring a second deactivation request, and the full pool coming back on reactivation after credits were returned.

// File: rtl/clc_pkg.sv
package clc_pkg;
  typedef enum logic [1:0] {
    ST_STOPPED    = 2'd0,
    ST_ACTIVATING = 2'd1,
    ST_ACTIVE     = 2'd2,
    ST_DEACT      = 2'd3
  } link_state_e;
endpackage

// File: rtl/clc_credit_ledger.sv
module clc_credit_ledger #(
  parameter int NUM_CREDITS = 8,
  localparam int CW = $clog2(NUM_CREDITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant_i,
  input  logic          consume_i,
  input  logic          return_i,
  input  logic          free_i,
  output logic [CW-1:0] out_o,
  output logic          avail_nz_o,
  output logic          err_o
);
  logic [CW-1:0] out_q, occ_q, avail_q;
  logic [CW-1:0] out_n, occ_n, avail_n;
  logic [1:0]    take;
  logic          over, free_ok, err_q;

  always_comb begin
    take    = {1'b0, consume_i} + {1'b0, return_i};
    over    = ({1'b0, out_q} < (CW+1)'(take));
    free_ok = free_i && (occ_q != '0);
    out_n   = out_q + CW'(grant_i) - (over ? '0 : CW'(take));
    occ_n   = occ_q + CW'(consume_i && !over) - CW'(free_ok);
    avail_n = avail_q - CW'(grant_i) + CW'(free_ok) + CW'(return_i && !over);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q   <= '0;
      occ_q   <= '0;
      avail_q <= CW'(NUM_CREDITS);
      err_q   <= 1'b0;
    end else begin
      out_q   <= out_n;
      occ_q   <= occ_n;
      avail_q <= avail_n;
      err_q   <= err_q | over;
    end
  end

  assign out_o      = out_q;
  assign avail_nz_o = (avail_q != '0);
  assign err_o      = err_q;

  // R4: held credits plus filled slots never exceed the pool
  p_pool_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, out_q} + {1'b0, occ_q}) <= (CW+1)'(NUM_CREDITS));
  // R10: error flag is sticky
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  // R11: error only rises after a take-away pulse
  p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(return_i || consume_i));
endmodule

// File: rtl/clc_link_fsm.sv
module clc_link_fsm
  import clc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        act_req_i,
  input  logic        buf_ready_i,
  input  logic        deact_req_i,
  input  logic        avail_nz_i,
  input  logic        out_zero_i,
  output link_state_e state_o,
  output logic        ack_o,
  output logic        hint_o,
  output logic        grant_d_o,
  output logic        grant_o
);
  link_state_e state_q, state_n;
  logic        ack_q, hint_q, grant_q;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_STOPPED:    if (act_req_i) state_n = ST_ACTIVATING;
      ST_ACTIVATING: if (!act_req_i) state_n = ST_STOPPED;
                     else if (buf_ready_i) state_n = ST_ACTIVE;
      ST_ACTIVE:     if (!act_req_i || deact_req_i) state_n = ST_DEACT;
      ST_DEACT:      if (!act_req_i && out_zero_i) state_n = ST_STOPPED;
      default:       state_n = ST_STOPPED;
    endcase
  end

  assign grant_d_o = (state_q == ST_ACTIVE) && act_req_i && !deact_req_i && avail_nz_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_STOPPED;
      ack_q   <= 1'b0;
      hint_q  <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      state_q <= state_n;
      ack_q   <= (state_n == ST_ACTIVE) || (state_n == ST_DEACT && act_req_i);
      grant_q <= grant_d_o;
      if (!act_req_i)
        hint_q <= 1'b0;
      else if (state_q == ST_ACTIVE && deact_req_i)
        hint_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign ack_o   = ack_q;
  assign hint_o  = hint_q;
  assign grant_o = grant_q;

  // R2: acknowledge rises only after request and buffer ready
  p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(act_req_i && buf_ready_i));
  // R5: grants only follow an active cycle
  p_grant_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> $past(state_q == ST_ACTIVE && act_req_i));
  // R6: hint released once the request is gone
  p_hint_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !act_req_i |=> !hint_o);
  // R9: stopping requires a drained count and no request
  p_stop_drained_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_DEACT && state_q == ST_STOPPED) |-> $past(out_zero_i && !act_req_i));
endmodule

// File: rtl/credit_link_ctrl.sv
module credit_link_ctrl
  import clc_pkg::*;
#(
  parameter int NUM_CREDITS = 8,
  localparam int CW = $clog2(NUM_CREDITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_req_i,
  output logic          act_ack_o,
  input  logic          buf_ready_i,
  input  logic          deact_req_i,
  output logic          deact_hint_o,
  output logic          credit_grant_o,
  input  logic          credit_return_i,
  input  logic          pkt_consume_i,
  input  logic          slot_free_i,
  output logic [CW-1:0] credits_out_o,
  output logic [1:0]    link_state_o,
  output logic          credit_err_o
);
  logic        grant_d, avail_nz;
  link_state_e st;

  clc_link_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_req_i   (act_req_i),
    .buf_ready_i (buf_ready_i),
    .deact_req_i (deact_req_i),
    .avail_nz_i  (avail_nz),
    .out_zero_i  (credits_out_o == '0),
    .state_o     (st),
    .ack_o       (act_ack_o),
    .hint_o      (deact_hint_o),
    .grant_d_o   (grant_d),
    .grant_o     (credit_grant_o)
  );

  clc_credit_ledger #(.NUM_CREDITS(NUM_CREDITS)) u_ledger (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant_i    (grant_d),
    .consume_i  (pkt_consume_i),
    .return_i   (credit_return_i),
    .free_i     (slot_free_i),
    .out_o      (credits_out_o),
    .avail_nz_o (avail_nz),
    .err_o      (credit_err_o)
  );

  assign link_state_o = st;
endmodule

// File: tb/credit_link_ctrl_bench.sv
module credit_link_ctrl_bench;
  localparam int N  = 4;
  localparam int CW = $clog2(N + 1);
  localparam int NROWS = 27;
  // {req rdy deact cons free ret}_{state}_{ack grant hint err}_{out}
  localparam logic [15:0] VEC [NROWS] = '{
    16'b100000_01_0000_0000, 16'b100000_01_0000_0000, 16'b110000_10_1000_0000,
    16'b100000_10_1100_0001, 16'b100000_10_1100_0010, 16'b100000_10_1100_0011,
    16'b100000_10_1100_0100, 16'b100000_10_1000_0100, 16'b100100_10_1000_0011,
    16'b100010_10_1000_0011, 16'b100000_10_1100_0100, 16'b101000_11_1010_0100,
    16'b100001_11_1010_0011, 16'b000000_11_0000_0011, 16'b001000_11_0000_0011,
    16'b000001_11_0000_0010, 16'b000100_11_0000_0001, 16'b000001_11_0000_0000,
    16'b000000_00_0000_0000, 16'b000010_00_0000_0000, 16'b110000_01_0000_0000,
    16'b110000_10_1000_0000, 16'b100000_10_1100_0001, 16'b100000_10_1100_0010,
    16'b100000_10_1100_0011, 16'b100000_10_1100_0100, 16'b100000_10_1000_0100
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, rdy = 0, deact = 0, cons = 0, fre = 0, ret = 0;
  logic ack, grant, hint, err;
  logic [CW-1:0] outc;
  logic [1:0] st;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  credit_link_ctrl #(.NUM_CREDITS(N)) u_credit_link_ctrl (
    .clk(clk), .rst_n(rst_n), .act_req_i(req), .act_ack_o(ack),
    .buf_ready_i(rdy), .deact_req_i(deact), .deact_hint_o(hint),
    .credit_grant_o(grant), .credit_return_i(ret), .pkt_consume_i(cons),
    .slot_free_i(fre), .credits_out_o(outc), .link_state_o(st), .credit_err_o(err)
  );

  function automatic string tag(int i);
    if (i <= 2) return "R2";
    if (i <= 6) return "R3";
    if (i <= 10) return "R4";
    if (i == 11) return "R5";
    if (i == 12) return "R6";
    if (i == 13) return "R9";
    if (i == 14) return "R7";
    if (i == 15) return "R8";
    if (i == 16) return "R12";
    if (i <= 19) return "R9";
    if (i <= 21) return "R2";
    return "R8";
  endfunction

  task automatic check(string r, logic [9:0] act, logic [9:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {state,ack,grant,hint,err,out} actual %b expected %b", r, act, exp);
    end
  endtask

  function automatic logic [9:0] obs();
    return {st, ack, grant, hint, err, 4'(outc)};
  endfunction

  task automatic drive(logic [5:0] s);
    @(negedge clk);
    {req, rdy, deact, cons, fre, ret} = s;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    {req, rdy, deact, cons, fre, ret} = '0;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(20000 * 10);
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R1", obs(), 10'b00_0000_0000);

    for (int i = 0; i < NROWS; i++) begin
      drive(VEC[i][15:10]);
      check(tag(i), obs(), VEC[i][9:0]);
    end

    // R2: request withdrawn while activating
    do_reset();
    drive(6'b100000);
    check("R2", obs(), 10'b01_0000_0000);
    drive(6'b000000);
    check("R2", obs(), 10'b00_0000_0000);

    // R11: return with nothing outstanding, then sticky (R10)
    drive(6'b000001);
    check("R11", obs(), 10'b00_0001_0000);
    drive(6'b000000);
    check("R10", obs(), 10'b00_0001_0000);

    // R10: consume with nothing outstanding
    do_reset();
    check("R1", obs(), 10'b00_0000_0000);
    drive(6'b000100);
    check("R10", obs(), 10'b00_0001_0000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule